// File: doc/BRIEF.md
# Hub Status-Change Interrupt Endpoint Responder

This block decides how the status-change interrupt endpoint of a USB hub answers each IN token from the host. Firmware writes a control/data register over a simple register bus. The register holds a force-stall bit, a change-pending bit and a bitmap of six per-port change flags. A separate 4-bit byte-count field for the hub control endpoint also lives in this block, and the block only stores it. When the token decoder reports an IN token for this endpoint, the block picks one of three answers: a STALL handshake, a NAK handshake, or a one-byte data packet that carries the change bitmap. It then waits for the host ACK and keeps the DATA0/DATA1 toggle. Serial encoding, bit stuffing, CRC and token/address decoding belong to neighbouring logic.

The state machine has three states. `ST_IDLE` waits for a token. The transition *accept* (`tok_in` while idle) latches the answer and moves to `ST_RESPOND`. `ST_RESPOND` drives the response for exactly one cycle. From there, *handshake_done* returns to `ST_IDLE` after a STALL or NAK, and *data_sent* moves to `ST_WAIT_ACK` after data. `ST_WAIT_ACK` leaves by *acked* (`rx_ack`, which flips the toggle) or by *timed_out* (ACK_TIMEOUT cycles with no ACK, toggle kept). Both lead back to `ST_IDLE`.

Top module: `hub_intr_ep`

## Requirements
- R1: After reset both registers read 0, no response is driven, and the first data packet uses DATA0 (`tx_data1`=0).
- R2: With control bit 7 (force-stall) set, an accepted token is answered with `tx_kind`=2 (STALL).
- R3: Force-stall wins over the change-pending bit when both are set.
- R4: With bit 7 and bit 6 (change-pending) both clear, an accepted token is answered with `tx_kind`=1 (NAK).
- R5: With bit 6 set and bit 7 clear, an accepted token is answered with `tx_kind`=3 (DATA) and `tx_byte` = {2'b00, flags[5:0]}. Non-data responses drive `tx_byte`=0.
- R6: The hardware never clears the change-pending bit. Each later token gets data again until firmware clears the bit.
- R7: An ACK received in `ST_WAIT_ACK` flips the toggle, so the next data packet uses the other PID.
- R8: When no ACK arrives within ACK_TIMEOUT cycles, the toggle is unchanged and the next data packet repeats the PID.
- R9: A `clr_toggle` pulse forces the toggle to DATA0.
- R10: The answer is latched when the token is accepted. A register write in the same cycle or later applies only from the next token, and tokens that arrive while busy are ignored.
- R11: Register select 1 is the byte-count field, bits [3:0] read/write. Bits [7:4] read as 0.
- R12: Register select 0 reads back exactly what was written: bit 7 stall, bit 6 pending, bits [5:0] per-port flags.
- R13: Each accepted token produces exactly one `tx_valid` pulse, one cycle long, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control/data register, 1 = byte-count field |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tok_in | input | 1 | Decoded IN token for this endpoint (one-cycle pulse) |
| rx_ack | input | 1 | Host ACK received (one-cycle pulse) |
| clr_toggle | input | 1 | Reset the data toggle to DATA0 |
| tx_valid | output | 1 | Response present this cycle |
| tx_kind | output | 2 | 0 none, 1 NAK, 2 STALL, 3 DATA |
| tx_data1 | output | 1 | DATA1 PID when set, DATA0 when clear (data only) |
| tx_byte | output | 8 | Data payload |

## Verification
The assertions check on every cycle that a response is one cycle long and follows each accepted token, that stall and NAK are chosen from the register state at acceptance, that the upper payload bits are zero, that the toggle moves only on ACK or clear, and that only a firmware write can drop the pending bit. Other behaviours show only in the bench's scenarios, because they need ordered sequences: alternating PIDs over successive ACKs, repeating a PID after a timeout, a write in the same cycle as a token still yielding the old answer, and a token ignored while waiting for ACK.

// File: rtl/hub_ep_pkg.sv
package hub_ep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RESPOND  = 2'd1,
        ST_WAIT_ACK = 2'd2
    } ep_state_t;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_DATA  = 2'd3
    } rsp_kind_t;
endpackage

// File: rtl/hub_ep_regs.sv
module hub_ep_regs #(
    parameter int REG_W  = 8,
    parameter int FLAG_W = 6,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              stall,
    output logic              pend,
    output logic [FLAG_W-1:0] flags
);
    localparam int STALL_BIT = REG_W - 1;
    localparam int PEND_BIT  = REG_W - 2;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall <= 1'b0;
            pend  <= 1'b0;
            flags <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            if (sel) begin
                cnt_q <= wdata[CNT_W-1:0];
            end else begin
                stall <= wdata[STALL_BIT];
                pend  <= wdata[PEND_BIT];
                flags <= wdata[FLAG_W-1:0];
            end
        end
    end

    always_comb begin
        if (sel) rdata = {{(REG_W-CNT_W){1'b0}}, cnt_q};
        else     rdata = {stall, pend, flags};
    end
endmodule

// File: rtl/hub_ep_toggle.sv
module hub_ep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flip,
    output logic tog
);
    always_ff @(posedge clk) begin
        if (!rst_n)    tog <= 1'b0;
        else if (clr)  tog <= 1'b0;
        else if (flip) tog <= ~tog;
    end
endmodule

// File: rtl/hub_ep_fsm.sv
module hub_ep_fsm
    import hub_ep_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int FLAG_W      = 6,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in,
    input  logic              rx_ack,
    input  logic              stall,
    input  logic              pend,
    input  logic [FLAG_W-1:0] flags,
    input  logic              tog,
    output ep_state_t         state,
    output logic              flip,
    output logic              tx_valid,
    output rsp_kind_t         tx_kind,
    output logic              tx_data1,
    output logic [REG_W-1:0]  tx_byte
);
    localparam int TMR_W = (ACK_TIMEOUT > 2) ? $clog2(ACK_TIMEOUT) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(ACK_TIMEOUT - 1);

    ep_state_t         nxt;
    rsp_kind_t         snap_kind;
    logic [FLAG_W-1:0] snap_flags;
    logic              snap_tog;
    logic [TMR_W-1:0]  tmr;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (tok_in) nxt = ST_RESPOND;
            ST_RESPOND:  nxt = (snap_kind == RSP_DATA) ? ST_WAIT_ACK : ST_IDLE;
            ST_WAIT_ACK: if (rx_ack || tmr == TMR_LAST) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register, snapshot and ack timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            snap_kind  <= RSP_NONE;
            snap_flags <= '0;
            snap_tog   <= 1'b0;
            tmr        <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && tok_in) begin
                if (stall)     snap_kind <= RSP_STALL;
                else if (pend) snap_kind <= RSP_DATA;
                else           snap_kind <= RSP_NAK;
                snap_flags <= flags;
                snap_tog   <= tog;
            end
            if (state == ST_WAIT_ACK) tmr <= tmr + 1'b1;
            else                      tmr <= '0;
        end
    end

    // outputs
    always_comb begin
        flip     = (state == ST_WAIT_ACK) && rx_ack;
        tx_valid = (state == ST_RESPOND);
        tx_kind  = RSP_NONE;
        tx_data1 = 1'b0;
        tx_byte  = '0;
        if (state == ST_RESPOND) begin
            tx_kind = snap_kind;
            if (snap_kind == RSP_DATA) begin
                tx_data1 = snap_tog;
                tx_byte  = {{(REG_W-FLAG_W){1'b0}}, snap_flags};
            end
        end
    end
endmodule

// File: rtl/hub_intr_ep.sv
module hub_intr_ep
    import hub_ep_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int FLAG_W      = 6,
    parameter int CNT_W       = 4,
    parameter int ACK_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             tok_in,
    input  logic             rx_ack,
    input  logic             clr_toggle,
    output logic             tx_valid,
    output logic [1:0]       tx_kind,
    output logic             tx_data1,
    output logic [REG_W-1:0] tx_byte
);
    logic              stall_q;
    logic              pend_q;
    logic [FLAG_W-1:0] flags_q;
    logic              tog_q;
    logic              flip;
    ep_state_t         st;
    rsp_kind_t         kind;

    hub_ep_regs #(.REG_W(REG_W), .FLAG_W(FLAG_W), .CNT_W(CNT_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .stall (stall_q),
        .pend  (pend_q),
        .flags (flags_q)
    );

    hub_ep_toggle u_tog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_toggle),
        .flip  (flip),
        .tog   (tog_q)
    );

    hub_ep_fsm #(.REG_W(REG_W), .FLAG_W(FLAG_W), .ACK_TIMEOUT(ACK_TIMEOUT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_in   (tok_in),
        .rx_ack   (rx_ack),
        .stall    (stall_q),
        .pend     (pend_q),
        .flags    (flags_q),
        .tog      (tog_q),
        .state    (st),
        .flip     (flip),
        .tx_valid (tx_valid),
        .tx_kind  (kind),
        .tx_data1 (tx_data1),
        .tx_byte  (tx_byte)
    );

    assign tx_kind = kind;
endmodule

// File: rtl/hub_intr_ep_chk.sv
module hub_intr_ep_chk #(
    parameter int REG_W  = 8,
    parameter int FLAG_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic             reg_sel,
    input logic             tok_in,
    input logic             rx_ack,
    input logic             clr_toggle,
    input logic             tx_valid,
    input logic [1:0]       tx_kind,
    input logic [REG_W-1:0] tx_byte,
    input logic [1:0]       st,
    input logic             stall_q,
    input logic             pend_q,
    input logic             tog_q
);
    logic accept;
    assign accept = tok_in && (st == 2'd0);

    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid); // R13
    AST_TOKEN_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> tx_valid); // R13
    AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && stall_q) |=> (tx_kind == 2'd2)); // R3
    AST_NAK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !stall_q && !pend_q) |=> (tx_kind == 2'd1)); // R4
    AST_PAYLOAD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_kind == 2'd3) |-> (tx_byte[REG_W-1:FLAG_W] == '0)); // R5
    AST_TOGGLE_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_q != $past(tog_q)) |-> $past(rx_ack || clr_toggle)); // R8
    AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_toggle |=> !tog_q); // R9
    AST_PEND_FW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(reg_wr_en && !reg_sel)); // R6
endmodule

bind hub_intr_ep hub_intr_ep_chk #(.REG_W(REG_W), .FLAG_W(FLAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_sel    (reg_sel),
    .tok_in     (tok_in),
    .rx_ack     (rx_ack),
    .clr_toggle (clr_toggle),
    .tx_valid   (tx_valid),
    .tx_kind    (tx_kind),
    .tx_byte    (tx_byte),
    .st         (st),
    .stall_q    (stall_q),
    .pend_q     (pend_q),
    .tog_q      (tog_q)
);

// File: tb/hub_intr_ep_tb.sv
module hub_intr_ep_tb;
    localparam int TMO = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tok_in = 1'b0;
    logic       rx_ack = 1'b0;
    logic       clr_toggle = 1'b0;
    logic       tx_valid;
    logic [1:0] tx_kind;
    logic       tx_data1;
    logic [7:0] tx_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] kind;
        logic       pid1;
        logic [7:0] data;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    hub_intr_ep #(.ACK_TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_in(tok_in),
        .rx_ack(rx_ack), .clr_toggle(clr_toggle), .tx_valid(tx_valid),
        .tx_kind(tx_kind), .tx_data1(tx_data1), .tx_byte(tx_byte)
    );

    // monitor: pops expected responses and compares
    always @(negedge clk) begin
        if (rst_n && tx_valid && !done) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected response kind=%0d exp none", tx_kind);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (tx_kind !== e.kind || tx_byte !== e.data ||
                    (e.kind == 2'd3 && tx_data1 !== e.pid1)) begin
                    fails++;
                    $display("FAIL %s: kind=%0d pid1=%0b byte=%02h exp kind=%0d pid1=%0b byte=%02h",
                             e.req, tx_kind, tx_data1, tx_byte, e.kind, e.pid1, e.data);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_sel = sel;
        #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    // driver: push expected item, then issue the token
    task automatic token(input logic [1:0] k, input logic p, input logic [7:0] d, input string req);
        exp_t e;
        e.kind = k; e.pid1 = p; e.data = d; e.req = req;
        sb.push_back(e);
        @(negedge clk);
        tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tx_valid === 1'b0, "R1", {7'd0, tx_valid}, 8'h00);
        rst_n = 1'b1;
        rd(1'b0, 8'h00, "R1");
        rd(1'b1, 8'h00, "R1");

        // R11: byte count field
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'h0F, "R11");
        wr(1'b1, 8'h05);
        rd(1'b1, 8'h05, "R11");

        // R4: NAK
        wr(1'b0, 8'h00);
        token(2'd1, 1'b0, 8'h00, "R4");
        repeat (2) @(negedge clk);

        // R2 / R3: stall
        wr(1'b0, 8'h95);
        token(2'd2, 1'b0, 8'h00, "R2");
        repeat (2) @(negedge clk);
        wr(1'b0, 8'hEA);
        token(2'd2, 1'b0, 8'h00, "R3");
        repeat (2) @(negedge clk);

        // R12 / R5 / R1 / R7: data with DATA0 first
        wr(1'b0, 8'h6A);
        rd(1'b0, 8'h6A, "R12");
        token(2'd3, 1'b0, 8'h2A, "R5 R1");
        ack();
        rd(1'b0, 8'h6A, "R6");
        token(2'd3, 1'b1, 8'h2A, "R6 R7");
        ack();

        // R8: timeout keeps toggle
        token(2'd3, 1'b0, 8'h2A, "R7");
        repeat (TMO + 4) @(negedge clk);
        token(2'd3, 1'b0, 8'h2A, "R8");
        ack();

        // R9: clear toggle (toggle is 1 here)
        @(negedge clk);
        clr_toggle = 1'b1;
        @(negedge clk);
        clr_toggle = 1'b0;
        token(2'd3, 1'b0, 8'h2A, "R9");
        ack();

        // R10: write in the token cycle, token while busy
        begin
            exp_t e;
            e.kind = 2'd3; e.pid1 = 1'b1; e.data = 8'h2A; e.req = "R10";
            sb.push_back(e);
        end
        @(negedge clk);
        tok_in = 1'b1; reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h80;
        @(negedge clk);
        tok_in = 1'b0; reg_wr_en = 1'b0;
        @(negedge clk);
        tok_in = 1'b1;            // ignored: waiting for ACK
        @(negedge clk);
        tok_in = 1'b0;
        ack();
        token(2'd2, 1'b0, 8'h00, "R10");
        repeat (2) @(negedge clk);

        // R5: full bitmap
        wr(1'b0, 8'h7F);
        token(2'd3, 1'b0, 8'h3F, "R5");
        ack();
        repeat (4) @(negedge clk);

        // R13: every expected response appeared
        chk(sb.size() == 0, "R13", 8'(sb.size()), 8'h00);
        finish_run();
    end
endmodule